// File: doc/BRIEF.md
# Autonomous Fuse Word Reader

This block reads one 32-bit word out of a small one-time-programmable fuse array without software driving the macro's strobes and timing. Software writes a control register on a simple register bus. The control word carries a word address, an enable bit and a read command. The controller then walks a fixed, parameterised number of clock cycles, latches the fetched word into a data register and raises a sticky completion flag. An interrupt line follows that flag. Software clears the flag by writing a one to it.

The array holds 128 bytes, arranged as 32 words. Bytes 0 to 95 form the secure region and bytes 96 to 127 form the non-secure region. To reach non-secure byte offset `b`, a caller biases the offset by 96 and fetches word `(b+96)/4`. The fuse contents are behavioural: word `k` holds a value computed from a seed. Programming the fuses and protecting the secure region are out of scope.

Top module: `fuse_autoread_ctrl`

## Requirements
- R1: After a synchronous reset, the status, data and control registers read 0 and `irq` is low.
- R2: Three offsets are decoded. Status is at byte offset 0x18, data is at 0x20 and control is at 0x24. A read of any other offset returns 0. `rd_data` presents the register addressed in a cycle one clock later.
- R3: A fetch starts only on a write to control with bit 0 (enable) and bit 1 (read command) both set. The 10-bit word address is taken from bits 25:16. A write with either bit clear starts no fetch, and the address field keeps the last started address.
- R4: Completion comes exactly FETCH_CYCLES clocks after the triggering write edge, and FETCH_CYCLES is at least 2. The default of 6 cycles at 125 MHz is well under 2 us. While a fetch runs, control bit 1 reads 1. Control bit 0 reads back the enable bit of the last write accepted while idle.
- R5: Data-out receives the whole fetched word. For word k < 32 that word is (0x9E3779B9 * (k+1)) mod 2^32. For k >= 32 it is 0. Word (b+96)/4 serves non-secure byte offset b.
- R6: Status bit 0 is the completion flag. Completion sets it. Writing 1 to it clears it and writing 0 has no effect. If a completion and a clearing write fall on the same edge, the flag stays set.
- R7: `irq` equals the completion flag in every cycle.
- R8: A control write during a fetch is ignored. The running fetch keeps its address and result, and no second fetch follows.
- R9: Data-out changes only on completion. Writes to the data offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Completion interrupt, follows status bit 0 |

## Verification
The hardest case to reach is a clearing write that lands on the same edge as a completion. The stimulus counts cycles from the triggering write edge and issues the write-1 on exactly the FETCH_CYCLES-th edge. A second hard case is a control write while a fetch is in flight. The bench retriggers on the edge right after the first trigger, with a different address, and then checks both the fetched word and the address read back. Random word addresses up to 63 cover both in-range words and words past the end of the array.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int BUS_AW = 8;
  localparam int DW = 32;
  localparam int WA = 10;
  localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_DATA   = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h24;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CMD_BIT = 1;
  localparam int CTRL_ADDR_LSB = 16;

  typedef struct packed {
    logic            go;
    logic [WA-1:0]   waddr;
  } fetch_req_t;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int WORDS = 32,
  parameter int DW = 32,
  parameter int WA = 10,
  parameter logic [31:0] SEED = 32'h9E3779B9
) (
  input  logic          clk,
  input  logic [WA-1:0] addr,
  output logic [DW-1:0] dout
);
  localparam int IW = $clog2(WORDS);

  logic [DW-1:0] mem [WORDS];

  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : g_word
      assign mem[g] = DW'(SEED * 32'(g + 1));
    end
  endgenerate

  logic in_range;
  assign in_range = (32'(addr) < WORDS);

  always_ff @(posedge clk) begin
    if (in_range) dout <= mem[addr[IW-1:0]];
    else          dout <= '0;
  end
endmodule

// File: rtl/fuse_fetch.sv
module fuse_fetch #(
  parameter int FETCH_CYCLES = 6,
  parameter int DW = 32,
  parameter int WA = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  fuse_pkg::fetch_req_t req,
  input  logic [DW-1:0] arr_dout,
  output logic [WA-1:0] arr_addr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] word_q
);
  localparam int CW = $clog2(FETCH_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FETCH_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic [WA-1:0] addr_q;

  assign arr_addr = addr_q;
  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else if (!busy) begin
      if (req.go) begin
        busy   <= 1'b1;
        cnt    <= '0;
        addr_q <= req.waddr;
      end
    end else if (done) begin
      busy   <= 1'b0;
      word_q <= arr_dout;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    req.go |-> !busy);
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(addr_q));
  assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(FETCH_CYCLES)));
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(word_q));
endmodule

// File: rtl/fuse_regs.sv
module fuse_regs #(
  parameter int BUS_AW = 8,
  parameter int DW = 32,
  parameter int WA = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DW-1:0]     word_q,
  output fuse_pkg::fetch_req_t req,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  import fuse_pkg::*;

  logic          flag_q, flag_d;
  logic          en_q;
  logic [WA-1:0] last_addr_q;
  logic          wr_ctrl, wr_stat;
  logic [DW-1:0] ctrl_view, rd_d;
  logic          unused_bits;

  assign unused_bits = ^{bus_wdata[DW-1:CTRL_ADDR_LSB+WA], bus_wdata[CTRL_ADDR_LSB-1:2]};

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat = bus_wr && (bus_addr == OFS_STATUS);

  assign req.go    = wr_ctrl && !busy && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_CMD_BIT];
  assign req.waddr = bus_wdata[CTRL_ADDR_LSB +: WA];

  always_comb begin
    flag_d = flag_q;
    if (wr_stat && bus_wdata[0]) flag_d = 1'b0;
    if (done) flag_d = 1'b1;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_ADDR_LSB +: WA] = last_addr_q;
    ctrl_view[CTRL_CMD_BIT] = busy;
    ctrl_view[CTRL_EN_BIT]  = en_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_STATUS: rd_d = DW'(flag_q);
      OFS_DATA:   rd_d = word_q;
      OFS_CTRL:   rd_d = ctrl_view;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q      <= 1'b0;
      irq         <= 1'b0;
      en_q        <= 1'b0;
      last_addr_q <= '0;
      rd_data     <= '0;
    end else begin
      flag_q  <= flag_d;
      irq     <= flag_d;
      rd_data <= rd_d;
      if (wr_ctrl && !busy) en_q <= bus_wdata[CTRL_EN_BIT];
      if (req.go) last_addr_q <= req.waddr;
    end
  end

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    irq == flag_q);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> flag_q);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && bus_wdata[0] && !done) |=> !flag_q);
  assert_flag_zero_write_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wr_stat && !bus_wdata[0]) |=> flag_q);
endmodule

// File: rtl/fuse_autoread_ctrl.sv
module fuse_autoread_ctrl #(
  parameter int FETCH_CYCLES = 6,
  parameter int WORDS = 32,
  parameter logic [31:0] SEED = 32'h9E3779B9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] rd_data,
  output logic        irq
);
  import fuse_pkg::*;

  fetch_req_t    req;
  logic [WA-1:0] arr_addr;
  logic [DW-1:0] arr_dout, word_q;
  logic          busy, done;

  fuse_regs #(.BUS_AW(BUS_AW), .DW(DW), .WA(WA)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done), .word_q(word_q),
    .req(req), .rd_data(rd_data), .irq(irq)
  );

  fuse_fetch #(.FETCH_CYCLES(FETCH_CYCLES), .DW(DW), .WA(WA)) u_fetch (
    .clk(clk), .rst(rst), .req(req), .arr_dout(arr_dout),
    .arr_addr(arr_addr), .busy(busy), .done(done), .word_q(word_q)
  );

  fuse_array #(.WORDS(WORDS), .DW(DW), .WA(WA), .SEED(SEED)) u_array (
    .clk(clk), .addr(arr_addr), .dout(arr_dout)
  );

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTRL && bus_wdata[1:0] == 2'b11 && !busy) |=> busy);
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: tb/sim_fuse_autoread_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_autoread_ctrl;
  localparam int N = 6;
  localparam logic [7:0] A_ST = 8'h18, A_DT = 8'h20, A_CT = 8'h24;

  logic clk = 0, rst = 1, bus_wr = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rd_data;
  logic irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fuse_autoread_ctrl #(.FETCH_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] p;
    p = 32'h9E3779B9 * 32'(k + 1);
    return (k < 32) ? p : 32'h0;
  endfunction

  function automatic logic [31:0] ctrl_word(input int a, input logic [1:0] b);
    return (32'(a) << 16) | 32'(b);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 0;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic fetch(input int a, output logic [31:0] d);
    wr(A_CT, ctrl_word(a, 2'b11));
    repeat (N + 1) @(negedge clk);
    rd(A_DT, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 irq", 32'(irq), 0);
    rd(A_ST, v); chk("R1 status", v, 0);
    rd(A_DT, v); chk("R1 data", v, 0);
    rd(A_CT, v); chk("R1 ctrl", v, 0);
    rd(8'h00, v); chk("R2 unused 00", v, 0);
    rd(8'h1C, v); chk("R2 unused 1c", v, 0);

    // R4 latency and busy readback
    wr(A_CT, ctrl_word(5, 2'b11));
    rd(A_CT, v); chk("R4 busy readback", v, ctrl_word(5, 2'b11));
    repeat (N - 2) @(negedge clk);
    chk("R4 irq before completion", 32'(irq), 0);
    @(negedge clk);
    chk("R4 irq at completion", 32'(irq), 1);
    rd(A_DT, v); chk("R5 word 5", v, exp_word(5));
    rd(A_CT, v); chk("R4 idle readback", v, ctrl_word(5, 2'b01));
    // R6 write 0 no effect, write 1 clears
    wr(A_ST, 0); rd(A_ST, v); chk("R6 zero write", v, 1);
    chk("R7 irq high", 32'(irq), 1);
    wr(A_ST, 1); rd(A_ST, v); chk("R6 w1c", v, 0);
    chk("R7 irq low", 32'(irq), 0);
    // R9 data write ignored
    wr(A_DT, 32'hFFFF_FFFF); rd(A_DT, v); chk("R9 data write", v, exp_word(5));

    // R3 incomplete triggers
    wr(A_CT, ctrl_word(7, 2'b01));
    repeat (N + 2) @(negedge clk);
    chk("R3 no fetch en only", 32'(irq), 0);
    rd(A_CT, v); chk("R3 ctrl en only", v, ctrl_word(5, 2'b01));
    wr(A_CT, ctrl_word(7, 2'b10));
    repeat (N + 2) @(negedge clk);
    chk("R3 no fetch cmd only", 32'(irq), 0);
    rd(A_DT, v); chk("R3 data kept", v, exp_word(5));

    // R8 retrigger during fetch
    wr(A_CT, ctrl_word(9, 2'b11));
    wr(A_CT, ctrl_word(20, 2'b11));
    repeat (N + 1) @(negedge clk);
    rd(A_DT, v); chk("R8 data first addr", v, exp_word(9));
    rd(A_CT, v); chk("R8 addr kept", v, ctrl_word(9, 2'b01));
    wr(A_ST, 1);
    repeat (N + 2) @(negedge clk);
    chk("R8 no second fetch", 32'(irq), 0);

    // R6 set wins over same-edge clear; word 26 = non-secure byte 8
    wr(A_CT, ctrl_word(26, 2'b11));
    repeat (N - 1) @(negedge clk);
    wr(A_ST, 1);
    rd(A_ST, v); chk("R6 set wins", v, 1);
    rd(A_DT, v); chk("R5 non-secure word", v, exp_word(26));
    wr(A_ST, 1);

    // R5 boundaries
    fetch(31, v); chk("R5 last word", v, exp_word(31)); wr(A_ST, 1);
    fetch(32, v); chk("R5 past end", v, 0); wr(A_ST, 1);
    fetch(1023, v); chk("R5 max addr", v, 0); wr(A_ST, 1);
    fetch(0, v); chk("R5 word 0", v, exp_word(0)); wr(A_ST, 1);

    for (int i = 0; i < 30; i++) begin
      int a;
      a = int'($urandom_range(0, 63));
      fetch(a, v); chk("R5 random", v, exp_word(a));
      wr(A_ST, 1);
      chk("R7 random clear", 32'(irq), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule